// File: doc/BRIEF.md
# Timed Fault Recovery Supervisor

This block sits on the controller side of a stepper driver that latches its overcurrent protection. It watches two sources of fault evidence. One is the driver's active-low fault line. The other is a status word that the controller polls over the serial bus. When either source reports a fault, the block orders the motor sequencer to stop. It then waits out a long hold-off before it requests a single control-register write that sets the clear-fault bit.

A latched overcurrent cannot show whether the short has gone until the outputs are enabled again. For that reason the block never retries at once. After each clear write it waits a short settle window and then looks at the fault evidence once. If the fault has come back, it starts a new hold-off. If the fault is gone, the motor may run again. A counter of consecutive attempts raises a sticky diagnostic request once it reaches a limit.

The clear-fault write leaves through a valid/ready pair and goes to the serial-bus master, which is outside this block. The source raises `wr_valid` and holds it, with `wr_data` unchanged, until it sees `wr_ready` high at a rising edge. That edge is the only transfer. The sink may hold `wr_ready` low for any number of cycles. The supervisor simply stays in its write phase, and no hold-off or settle time passes during that wait.

Top module: `fault_recovery_sup`

## Requirements
- R1: A fault is detected when the fault line, after `SYNC_STAGES` flip-flops, reads low, or when the most recently polled status word has bit 11 (mask 0x0800) set. No other status bit causes detection.
- R2: `motor_stop` is low while running normally. It goes high in the cycle after detection, when the hold-off starts, and stays high until a clear succeeds.
- R3: `wr_valid` rises exactly `HOLD_CYC` cycles after the hold-off starts. No write is requested during the hold-off.
- R4: The requested word is 0x0CBA, the running control word 0x0C3A with bit 7 set. `wr_valid` and `wr_data` stay stable until accepted, and each attempt transfers exactly once.
- R5: The fault evidence is sampled `SETTLE_CYC` cycles after the write is accepted. If a fault is present, a new hold-off starts in that same edge and `motor_stop` stays high.
- R6: If no fault is present at that sample, `motor_stop` falls and the attempt count returns to zero.
- R7: `attempt_cnt` increases by one on each accepted clear write and saturates at `RETRY_LIMIT`.
- R8: `diag_req` is set by an accepted write made at or beyond the limit. It stays set until `diag_clr` is high at a clock edge. If both happen in the same edge, the set wins.
- R9: After reset, `motor_stop`, `wr_valid` and `diag_req` are low and `attempt_cnt` is zero.
- R10: An accepted clear write forgets the remembered overcurrent bit. A status word polled in the same or a later cycle replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_n | input | 1 | Driver fault line, active low, asynchronous |
| stat_vld | input | 1 | Polled status word valid this cycle |
| stat_word | input | 16 | Polled status word |
| diag_clr | input | 1 | Clears the sticky diagnostic request |
| wr_valid | output | 1 | Clear-fault write requested |
| wr_ready | input | 1 | Write accepted by the bus master |
| wr_data | output | 16 | Control word to write |
| motor_stop | output | 1 | Motor sequencer must halt |
| attempt_cnt | output | CNT_W | Consecutive clear attempts |
| diag_req | output | 1 | Sticky diagnostic-code request |

## Verification
The accepted write that reaches the attempt limit can fall in the same edge as a `diag_clr` pulse from software. That edge is asked both to set and to clear the diagnostic request. The bench first clears the request, then runs a persistent fault through three attempts, and raises `diag_clr` together with `wr_ready` for the third write. It then judges that `diag_req` still reads high after that edge, as the set-wins rule demands. Hold-off and settle lengths are checked by counting cycles at the ports, for both the line and the polled-word sources, under several back-pressure lengths.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HOLD   = 2'd1,
    ST_WRITE  = 2'd2,
    ST_SETTLE = 2'd3
  } fr_state_e;

  localparam logic [15:0] FR_OCP_MASK  = 16'h0800;
  localparam logic [15:0] FR_CLR_WORD  = 16'h0CBA;
endpackage

// File: rtl/fr_detect.sv
module fr_detect #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] OCP_MASK    = 16'h0800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fault_n,
  input  logic        stat_vld,
  input  logic [15:0] stat_word,
  input  logic        clr_ack,
  output logic        fault_now
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ocp_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b1;
        else        sync_q <= fault_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], fault_n};
      end
    end
  endgenerate

  // Remembered overcurrent bit: a new poll overrides, an accepted clear forgets.
  always_ff @(posedge clk) begin
    if (!rst_n)        ocp_q <= 1'b0;
    else if (stat_vld) ocp_q <= |(stat_word & OCP_MASK);
    else if (clr_ack)  ocp_q <= 1'b0;
  end

  assign fault_now = !sync_q[SYNC_STAGES-1] || ocp_q;

  AST_OCP_FORGET: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ack && !stat_vld |=> !ocp_q); // R10
  AST_OCP_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |=> ocp_q == $past(stat_word[11])); // R1
endmodule

// File: rtl/fr_timer.sv
module fr_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  assign expired = en && (cnt_q == limit - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!en || expired) cnt_q <= '0;
    else                     cnt_q <= cnt_q + TW'(1);
  end

  AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt_q < limit); // R3
endmodule

// File: rtl/fr_attempts.sv
module fr_attempts #(
  parameter int RETRY_LIMIT = 8,
  parameter int CW          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr_cnt,
  input  logic          diag_clr,
  output logic [CW-1:0] cnt,
  output logic          diag
);
  logic hit;

  assign hit = inc && (cnt >= CW'(RETRY_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                                 cnt <= '0;
    else if (clr_cnt)                           cnt <= '0;
    else if (inc && (cnt < CW'(RETRY_LIMIT)))   cnt <= cnt + CW'(1);
  end

  // Set has priority over a simultaneous clear so a new limit event is never lost.
  always_ff @(posedge clk) begin
    if (!rst_n)        diag <= 1'b0;
    else if (hit)      diag <= 1'b1;
    else if (diag_clr) diag <= 1'b0;
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(RETRY_LIMIT)); // R7
  AST_DIAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    diag && !diag_clr |=> diag); // R8
endmodule

// File: rtl/fault_recovery_sup.sv
module fault_recovery_sup
  import fr_pkg::*;
#(
  parameter int HOLD_CYC    = 1_000_000_000,
  parameter int SETTLE_CYC  = 10_000,
  parameter int RETRY_LIMIT = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(RETRY_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_n,
  input  logic             stat_vld,
  input  logic [15:0]      stat_word,
  input  logic             diag_clr,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [15:0]      wr_data,
  output logic             motor_stop,
  output logic [CNT_W-1:0] attempt_cnt,
  output logic             diag_req
);
  localparam int TMAX = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int TW   = $clog2(TMAX + 1) + 1;

  fr_state_e     st_q, st_d;
  logic          fault_now, t_en, t_exp, accept, success;
  logic [TW-1:0] t_limit;

  assign accept  = (st_q == ST_WRITE) && wr_ready;
  assign success = (st_q == ST_SETTLE) && t_exp && !fault_now;
  assign t_en    = (st_q == ST_HOLD) || (st_q == ST_SETTLE);
  assign t_limit = (st_q == ST_HOLD) ? TW'(HOLD_CYC) : TW'(SETTLE_CYC);

  fr_detect #(.SYNC_STAGES(SYNC_STAGES), .OCP_MASK(FR_OCP_MASK)) detect_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_n   (fault_n),
    .stat_vld  (stat_vld),
    .stat_word (stat_word),
    .clr_ack   (accept),
    .fault_now (fault_now)
  );

  fr_timer #(.TW(TW)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (t_en),
    .limit   (t_limit),
    .expired (t_exp)
  );

  fr_attempts #(.RETRY_LIMIT(RETRY_LIMIT), .CW(CNT_W)) attempts_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (accept),
    .clr_cnt  (success),
    .diag_clr (diag_clr),
    .cnt      (attempt_cnt),
    .diag     (diag_req)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:    if (fault_now) st_d = ST_HOLD;
      ST_HOLD:   if (t_exp)     st_d = ST_WRITE;
      ST_WRITE:  if (wr_ready)  st_d = ST_SETTLE;
      ST_SETTLE: if (t_exp)     st_d = fault_now ? ST_HOLD : ST_RUN;
      default:                  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign wr_valid   = (st_q == ST_WRITE);
  assign wr_data    = FR_CLR_WORD;
  assign motor_stop = (st_q != ST_RUN);

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid); // R4
  AST_ONE_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_valid); // R4
  AST_STOP_WHILE_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> motor_stop); // R2
  AST_RUN_NEEDS_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(motor_stop) |-> attempt_cnt == '0); // R6
endmodule

// File: tb/fault_recovery_sup_tb_top.sv
module fault_recovery_sup_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD   = 20;
  localparam int SETTLE = 5;
  localparam int LIMIT  = 3;

  typedef struct packed {
    logic       line;
    logic [2:0] persist;
    logic [2:0] rdy_dly;
    logic       exp_diag;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 3'd0, 1'b0},
    '{1'b0, 3'd0, 3'd2, 1'b0},
    '{1'b1, 3'd1, 3'd1, 1'b0},
    '{1'b0, 3'd2, 3'd0, 1'b1},
    '{1'b1, 3'd4, 3'd3, 1'b1},
    '{1'b0, 3'd1, 3'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_n = 1'b1;
  logic        stat_vld = 1'b0;
  logic [15:0] stat_word = 16'h0000;
  logic        diag_clr = 1'b0;
  logic        wr_ready = 1'b0;
  logic        wr_valid, motor_stop, diag_req;
  logic [15:0] wr_data;
  logic [1:0]  attempt_cnt;
  int          cyc = 0;
  int          n_cmp = 0;
  int          n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fault_recovery_sup #(
    .HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE), .RETRY_LIMIT(LIMIT), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .fault_n(fault_n), .stat_vld(stat_vld),
    .stat_word(stat_word), .diag_clr(diag_clr), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .motor_stop(motor_stop),
    .attempt_cnt(attempt_cnt), .diag_req(diag_req)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  task automatic run_vec(input vec_t v, input int clr_at);
    int entry, expw, a, t;
    @(negedge clk);
    entry = cyc + (v.line ? 3 : 2);
    if (v.line) fault_n = 1'b0;
    else begin stat_vld = 1'b1; stat_word = 16'h0813; end
    @(negedge clk);
    stat_vld = 1'b0;
    while (cyc < entry - 1) @(negedge clk);
    chk(!motor_stop, "R2", "stop before detect", motor_stop, 0);
    @(negedge clk);
    chk(motor_stop, "R2", "stop at hold start", motor_stop, 1);
    expw = entry + HOLD;
    for (int k = 0; k <= int'(v.persist); k++) begin
      t = 0;
      while (!wr_valid && t < 1000) begin @(negedge clk); t++; end
      chk(cyc == expw, "R3", "write request cycle", cyc, expw);
      chk(wr_data == 16'h0CBA, "R4", "write word", wr_data, 16'h0CBA);
      for (int d = 0; d < int'(v.rdy_dly); d++) begin
        @(negedge clk);
        chk(wr_valid && wr_data == 16'h0CBA, "R4", "held under back-pressure",
            {wr_valid, wr_data}, 17'h10CBA);
      end
      wr_ready = 1'b1;
      if (k == clr_at) diag_clr = 1'b1;
      @(negedge clk);
      a = cyc;
      wr_ready = 1'b0;
      diag_clr = 1'b0;
      chk(!wr_valid, "R4", "single transfer", wr_valid, 0);
      chk(attempt_cnt == ((k + 1 > LIMIT) ? LIMIT : k + 1), "R7", "attempt count",
          attempt_cnt, (k + 1 > LIMIT) ? LIMIT : k + 1);
      if (k < int'(v.persist)) begin
        if (v.line) begin
          fault_n = 1'b1; @(negedge clk); fault_n = 1'b0;
        end else begin
          @(negedge clk); stat_vld = 1'b1; stat_word = 16'h0800;
          @(negedge clk); stat_vld = 1'b0;
        end
        expw = a + SETTLE + HOLD;
        while (cyc < a + SETTLE) @(negedge clk);
        chk(motor_stop, "R5", "stop kept after failed clear", motor_stop, 1);
      end else begin
        if (v.line) fault_n = 1'b1;
        else begin
          @(negedge clk); stat_vld = 1'b1; stat_word = 16'h0400;
          @(negedge clk); stat_vld = 1'b0;
        end
        while (cyc < a + SETTLE - 1) @(negedge clk);
        chk(motor_stop, "R5", "stop during settle", motor_stop, 1);
        @(negedge clk);
        chk(!motor_stop, "R6", "run after clear", motor_stop, 0);
        chk(attempt_cnt == 0, "R6", "count reset", attempt_cnt, 0);
      end
    end
    chk(diag_req == v.exp_diag, "R8", "diag request", diag_req, v.exp_diag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!motor_stop && !wr_valid && !diag_req && attempt_cnt == 0, "R9", "reset outputs",
        {motor_stop, wr_valid, diag_req, attempt_cnt}, 0);

    // R1: status word without bit 11 causes no detection
    stat_vld = 1'b1; stat_word = 16'hF7FF;
    @(negedge clk); stat_vld = 1'b0;
    repeat (10) @(negedge clk);
    chk(!motor_stop && !wr_valid, "R1", "non-overcurrent bits ignored", motor_stop, 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], -1);
      diag_clr = 1'b1; @(negedge clk); diag_clr = 1'b0;
      @(negedge clk);
      chk(!diag_req, "R8", "diag cleared by pulse", diag_req, 0);
      repeat (3) @(negedge clk);
    end

    // R8: limit write and diag_clr in the same edge, set wins
    run_vec('{1'b0, 3'd2, 3'd1, 1'b1}, 2);

    // R10: the accepted write forgets an earlier overcurrent poll
    diag_clr = 1'b1; @(negedge clk); diag_clr = 1'b0;
    run_vec('{1'b0, 3'd0, 3'd0, 1'b0}, -1);
    repeat (5) @(negedge clk);
    chk(!motor_stop, "R10", "no re-detect after clear", motor_stop, 0);

    finish_run();
  end
endmodule